// File: doc/BRIEF.md
# Command Completion Counter and Interrupt

This block sits beside one channel of a descriptor-driven data mover and turns the engine's per-command event pulses into a status word and a level interrupt. Each event advances a six-bit modulo-64 done count. Software records how far it has handled events by writing a six-bit processed count. The interrupt stays asserted while any event is unacknowledged, so an event that arrives between a status read and the acknowledging write cannot be lost.

A chain-start pulse marks the beginning of a new command list. The first event after it reports that the list was loaded, and every later event reports a finished node. The block shows this split on a level output and on a one-cycle pulse output.

The status word has three fields at fixed positions, because software decodes them: done count at bits 5:0, interrupt-active flag at bit 8 and processed count at bits 21:16. All other bits read as zero. The done field cannot be written.

Top module: `cmd_done_irq`

## Requirements
- R1: After reset the status word reads 0, `irq_o` is low, `list_loaded_o` is low and `node_done_o` is low.
- R2: Each cycle with `evt_i` high increments the done field (bits 5:0) by one. The new value is readable after that clock edge. With `evt_i` low the field holds.
- R3: The done field wraps from 63 to 0 (modulo 64).
- R4: A write (`reg_wr_i` high) loads `reg_wdata_i[21:16]` into the processed field. Bits 5:0 of the write data have no effect on the done field.
- R5: An event while `irq_en_i` is high sets the active flag (bit 8). An event while `irq_en_i` is low leaves the flag unchanged.
- R6: A write with bit 8 at 0 clears the flag. A write with bit 8 at 1 leaves the flag unchanged and never sets it.
- R7: `irq_o` is high in the same cycle whenever the flag is set, or whenever `irq_en_i` is high and the done and processed fields differ. Otherwise it is low.
- R8: When an event and a flag-clearing write fall in the same cycle, the done field still increments. The flag ends set when `irq_en_i` is high and the written processed value differs from the incremented done value. Otherwise it ends clear.
- R9: After a `chain_start_i` pulse, the next event sets `list_loaded_o` and produces no `node_done_o`. Each later event gives a one-cycle `node_done_o` pulse after its clock edge. The same rules apply to the first event after reset. An event in the same cycle as `chain_start_i` counts as the load of the new chain.
- R10: The pending count is (done − processed) mod 64. `irq_o` stays high with `irq_en_i` high while that count is non-zero, including across the wrap of the done field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Command event pulse from the engine |
| chain_start_i | input | 1 | Pulse marking the start of a new command list |
| irq_en_i | input | 1 | Interrupt enable |
| reg_wr_i | input | 1 | Status word write strobe |
| reg_wdata_i | input | 32 | Write data: processed count and flag-keep bit |
| reg_rdata_o | output | 32 | Status word: done, active flag, processed |
| irq_o | output | 1 | Level interrupt |
| list_loaded_o | output | 1 | The current chain's list has been loaded |
| node_done_o | output | 1 | One-cycle pulse per completed node |

## Verification
The assertions assume the following about the inputs:
- `evt_i` and `chain_start_i` are clean synchronous levels sampled once per edge.
- Any write carries meaningful bits in the processed and flag positions.
- `irq_en_i` changes only between cycles.

The stimulus drives every input on the falling edge and holds it for the whole cycle. It pairs events with writes only in deliberate race cycles. It toggles the enable only between steps, so the flag-set and irq checks always see a stable enable.

// File: rtl/cdi_pkg.sv
package cdi_pkg;

   // Chain tracking state: waiting for the list-load event, or counting nodes.
   typedef enum logic {
      CHAIN_WAIT_LOAD = 1'b0,
      CHAIN_RUNNING   = 1'b1
   } chain_e;

   // Decoded software write to the status word.
   typedef struct packed {
      logic       strobe;
      logic       keep_flag;
   } wr_ctl_t;

   function automatic bit fields_overlap(input int a_lsb, input int a_w,
                                         input int b_lsb, input int b_w);
      return (a_lsb < b_lsb + b_w) && (b_lsb < a_lsb + a_w);
   endfunction

endpackage

// File: rtl/cdi_done_ctr.sv
module cdi_done_ctr #(
   parameter int CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             evt_i,
   output logic [CNT_W-1:0] done_o,
   output logic [CNT_W-1:0] done_nxt_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   // Natural binary wrap gives modulo 2**CNT_W.
   assign done_nxt_o = evt_i ? cnt_q + ONE : cnt_q;
   assign done_o     = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= done_nxt_o;
   end

   p_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i |=> (done_o == $past(done_o) + ONE));

   p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !evt_i |=> $stable(done_o));

   p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i && (&done_o)) |=> (done_o == '0));

endmodule

// File: rtl/cdi_ack_ctl.sv
module cdi_ack_ctl #(
   parameter int CNT_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             evt_i,
   input  logic             irq_en_i,
   input  cdi_pkg::wr_ctl_t wr_i,
   input  logic [CNT_W-1:0] wr_proc_i,
   input  logic [CNT_W-1:0] done_nxt_i,
   output logic [CNT_W-1:0] proc_o,
   output logic             flag_o
);

   logic [CNT_W-1:0] proc_q;
   logic             flag_q;
   logic             flag_d;
   logic             set_ev;

   assign set_ev = evt_i & irq_en_i;

   always_comb begin
      flag_d = flag_q | set_ev;
      if (wr_i.strobe && !wr_i.keep_flag) begin
         // Clearing write: an event in the same cycle survives unless the
         // software value already covers it.
         flag_d = set_ev & (wr_proc_i != done_nxt_i);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         proc_q <= '0;
         flag_q <= 1'b0;
      end else begin
         if (wr_i.strobe) proc_q <= wr_proc_i;
         flag_q <= flag_d;
      end
   end

   assign proc_o = proc_q;
   assign flag_o = flag_q;

   p_proc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i.strobe |=> (proc_o == $past(wr_proc_i)));

   p_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_ev && !wr_i.strobe) |=> flag_o);

   p_noset_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!irq_en_i && !flag_o) |=> !flag_o);

   p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i.strobe && !wr_i.keep_flag && !evt_i) |=> !flag_o);

   p_race_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i.strobe && !wr_i.keep_flag && set_ev && (wr_proc_i != done_nxt_i))
      |=> flag_o);

endmodule

// File: rtl/cdi_chain_trk.sv
module cdi_chain_trk (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic evt_i,
   output logic loaded_o,
   output logic node_done_o
);
   import cdi_pkg::*;

   chain_e st_q, st_d;
   logic   node_q;

   always_comb begin
      st_d = st_q;
      if (start_i)    st_d = evt_i ? CHAIN_RUNNING : CHAIN_WAIT_LOAD;
      else if (evt_i) st_d = CHAIN_RUNNING;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= CHAIN_WAIT_LOAD;
         node_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         node_q <= evt_i && !start_i && (st_q == CHAIN_RUNNING);
      end
   end

   assign loaded_o    = (st_q == CHAIN_RUNNING);
   assign node_done_o = node_q;

   p_node_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      node_done_o |-> ($past(evt_i) && $past(loaded_o)));

   p_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!loaded_o && evt_i) |=> (loaded_o && !node_done_o));

endmodule

// File: rtl/cmd_done_irq.sv
module cmd_done_irq #(
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 6,
   parameter int DONE_LSB = 0,
   parameter int FLAG_BIT = 8,
   parameter int PROC_LSB = 16,
   parameter bit IRQ_REG  = 1'b0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              evt_i,
   input  logic              chain_start_i,
   input  logic              irq_en_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o,
   output logic              list_loaded_o,
   output logic              node_done_o
);
   import cdi_pkg::*;

   localparam logic [DATA_W-1:0] FIELD_MASK =
      ({{(DATA_W-CNT_W){1'b0}}, {CNT_W{1'b1}}} << PROC_LSB) |
      (DATA_W'(1) << FLAG_BIT);

   generate
      if (PROC_LSB + CNT_W > DATA_W || DONE_LSB + CNT_W > DATA_W
          || FLAG_BIT >= DATA_W) begin : g_bad_fit
         $error("status fields exceed the data width");
      end
      if (fields_overlap(DONE_LSB, CNT_W, PROC_LSB, CNT_W)
          || fields_overlap(DONE_LSB, CNT_W, FLAG_BIT, 1)
          || fields_overlap(PROC_LSB, CNT_W, FLAG_BIT, 1)) begin : g_bad_overlap
         $error("status fields overlap");
      end
   endgenerate

   logic [CNT_W-1:0] done, done_nxt, proc;
   logic             flag;
   wr_ctl_t          wr_ctl;
   logic             irq_raw;
   logic             unused_wbits;

   assign wr_ctl.strobe    = reg_wr_i;
   assign wr_ctl.keep_flag = reg_wdata_i[FLAG_BIT];
   assign unused_wbits     = ^(reg_wdata_i & ~FIELD_MASK);

   cdi_done_ctr #(.CNT_W(CNT_W)) u_done (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i),
      .done_o     (done),
      .done_nxt_o (done_nxt)
   );

   cdi_ack_ctl #(.CNT_W(CNT_W)) u_ack (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i),
      .irq_en_i   (irq_en_i),
      .wr_i       (wr_ctl),
      .wr_proc_i  (reg_wdata_i[PROC_LSB +: CNT_W]),
      .done_nxt_i (done_nxt),
      .proc_o     (proc),
      .flag_o     (flag)
   );

   cdi_chain_trk u_chain (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (chain_start_i),
      .evt_i       (evt_i),
      .loaded_o    (list_loaded_o),
      .node_done_o (node_done_o)
   );

   always_comb begin
      reg_rdata_o                       = '0;
      reg_rdata_o[DONE_LSB +: CNT_W]    = done;
      reg_rdata_o[FLAG_BIT]             = flag;
      reg_rdata_o[PROC_LSB +: CNT_W]    = proc;
   end

   assign irq_raw = flag | (irq_en_i & (done != proc));

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) irq_q <= 1'b0;
            else         irq_q <= irq_raw;
         end
         assign irq_o = irq_q;
      end else begin : g_irq_comb
         assign irq_o = irq_raw;

         p_irq_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            flag |-> irq_o);

         p_irq_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!flag && (done == proc)) |-> !irq_o);

         p_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (irq_en_i && ((done - proc) != '0)) |-> irq_o);
      end
   endgenerate

   p_rsvd_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((reg_rdata_o & ~FIELD_MASK & ~({{(DATA_W-CNT_W){1'b0}}, {CNT_W{1'b1}}}
        << DONE_LSB)) == '0));

endmodule

// File: tb/cmd_done_irq_tb_top.sv
`timescale 1ns/1ps
module cmd_done_irq_tb_top;

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        evt_i = 1'b0, chain_start_i = 1'b0, irq_en_i = 1'b0, reg_wr_i = 1'b0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        irq_o, list_loaded_o, node_done_o;

   always #10 clk = ~clk;

   cmd_done_irq dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_ni),
      .evt_i         (evt_i),
      .chain_start_i (chain_start_i),
      .irq_en_i      (irq_en_i),
      .reg_wr_i      (reg_wr_i),
      .reg_wdata_i   (reg_wdata_i),
      .reg_rdata_o   (reg_rdata_o),
      .irq_o         (irq_o),
      .list_loaded_o (list_loaded_o),
      .node_done_o   (node_done_o)
   );

   typedef struct {
      string       tag;
      logic [31:0] rd;
      logic        irq;
      logic        loaded;
      logic        node;
   } exp_t;

   exp_t exp_q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   finished = 0;

   logic [5:0] m_done = '0, m_proc = '0;
   logic       m_flag = 1'b0, m_loaded = 1'b0;

   task automatic step(input string tag, input logic e, input logic w,
                       input logic [5:0] wp, input logic wk,
                       input logic [5:0] wjunk, input logic st, input logic en);
      exp_t       x;
      logic [5:0] nd;
      logic       node;
      @(negedge clk);
      evt_i         = e;
      reg_wr_i      = w;
      chain_start_i = st;
      irq_en_i      = en;
      reg_wdata_i   = {10'h0, wp, 7'h0, wk, 2'h0, wjunk};
      nd   = e ? m_done + 6'd1 : m_done;
      node = e && m_loaded && !st;
      if (w && !wk) m_flag = e && en && (wp != nd);
      else          m_flag = m_flag | (e & en);
      if (w) m_proc = wp;
      m_loaded = e | (m_loaded & ~st);
      m_done   = nd;
      x.tag    = tag;
      x.rd     = {10'h0, m_proc, 7'h0, m_flag, 2'h0, m_done};
      x.irq    = m_flag | (en & (m_done != m_proc));
      x.loaded = m_loaded;
      x.node   = node;
      exp_q.push_back(x);
   endtask

   // Monitor: compare each expected item a little after the edge it belongs to.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            n_vec++;
            if (reg_rdata_o !== x.rd || irq_o !== x.irq ||
                list_loaded_o !== x.loaded || node_done_o !== x.node) begin
               n_bad++;
               $display("FAIL %s: rdata=%h irq=%b loaded=%b node=%b expected rdata=%h irq=%b loaded=%b node=%b",
                        x.tag, reg_rdata_o, irq_o, list_loaded_o, node_done_o,
                        x.rd, x.irq, x.loaded, x.node);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_ni = 1'b1;
      // R1 reset state
      step("R1", 0, 0, 6'd0, 0, 6'd0, 0, 0);
      // R2 R5 R9: events with enable off; first is the load, later ones are nodes
      step("R9", 1, 0, 6'd0, 0, 6'd0, 0, 0);
      step("R2", 1, 0, 6'd0, 0, 6'd0, 0, 0);
      step("R5", 1, 0, 6'd0, 0, 6'd0, 0, 0);
      // R7 R10: enable on with pending events
      step("R7", 0, 0, 6'd0, 0, 6'd0, 0, 1);
      // R4 R6: acknowledge with processed = 3
      step("R4", 0, 1, 6'd3, 0, 6'd0, 0, 1);
      // R4: junk in the done bits of a write is ignored
      step("R4", 0, 1, 6'd3, 0, 6'h3f, 0, 1);
      // R5: event with enable on sets the flag
      step("R5", 1, 0, 6'd0, 0, 6'd0, 0, 1);
      // R6: keep-flag write leaves it set even when counts match
      step("R6", 0, 1, 6'd4, 1, 6'd0, 0, 1);
      step("R6", 0, 1, 6'd4, 0, 6'd0, 0, 1);
      // R8: race, written value lags the new done count
      step("R8", 1, 1, 6'd4, 0, 6'd0, 0, 1);
      step("R8", 0, 1, 6'd5, 0, 6'd0, 0, 1);
      // R8: race, written value equals the new done count
      step("R8", 1, 1, 6'd6, 0, 6'd0, 0, 1);
      // R9: new chain, load event then a node
      step("R9", 0, 0, 6'd0, 0, 6'd0, 1, 1);
      step("R9", 1, 0, 6'd0, 0, 6'd0, 0, 0);
      step("R9", 1, 0, 6'd0, 0, 6'd0, 0, 0);
      // R9: event coinciding with chain start is the load
      step("R9", 1, 0, 6'd0, 0, 6'd0, 1, 0);
      // R3: run the done count through the wrap (9 -> 1 takes 56 events)
      for (int i = 0; i < 56; i++) step("R3", 1, 0, 6'd0, 0, 6'd0, 0, 0);
      // R10: pending across the wrap keeps irq high, then clears on ack
      step("R10", 0, 1, 6'd62, 0, 6'd0, 0, 1);
      step("R10", 0, 1, 6'd1, 0, 6'd0, 0, 1);
      step("R7", 0, 0, 6'd0, 0, 6'd0, 0, 0);
      repeat (3) @(posedge clk);
      #5;
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule